// File: doc/BRIEF.md
# Masked Sub-Group Issue Sequencer

This block takes warp instructions of 32 threads, each with a per-thread active mask, and issues them onto a 16-lane SIMD datapath one sub-group per cycle. A warp splits into two aligned 16-lane sub-groups. Any sub-group whose lanes are all inactive is never issued, so a warp costs as many cycles as it has non-empty sub-groups: two, one or none.

A per-warp packing mode moves the active threads into the lowest lanes, in ascending thread order, before the sub-groups are formed. A warp with at most 16 active threads then always fits into one issue, even when its active threads are spread across both halves. Every issue carries a lane map that gives, for each datapath lane, the original thread index, so results can be returned to the right threads. Warps enter through a valid/ready handshake. Issues leave one per cycle with no back-pressure.

Top module: `subgroup_issue_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: In direct mode (`in_pack`=0), sub-group g is issued exactly when `in_mask[16g+15:16g]` is non-zero, and its `out_mask` equals that slice. An issued mask is never all zero.
- R3: A warp accepted at a clock edge issues its first sub-group in the cycle that follows that edge. It issues on as many consecutive cycles as it has non-empty sub-groups.
- R4: The sub-groups of a warp issue in strictly ascending `out_sub` order, with one sub-group per cycle and no gaps.
- R5: `in_ready` is 0 whenever the issue in progress is not the last one of its warp. It is 1 in the cycle that issues the last sub-group, so the next warp can be accepted at that edge.
- R6: In packed mode (`in_pack`=1), with k active threads, lane l of sub-group g is active exactly when 16g+l < k. Its map entry holds the index of the (16g+l)-th active thread, counted in ascending order from 0. The entries of inactive packed lanes hold 0.
- R7: A warp with an all-zero mask is accepted, produces no issue, and leaves `in_ready` at 1.
- R8: `out_instr` equals the instruction word of the warp being issued. `out_last` is 1 exactly on the final issue of a warp.
- R9: The lane map puts the 5-bit entry for lane l at bits [5l+4:5l]. In direct mode, lane l of sub-group g maps to thread 16g+l, whether or not that lane is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Warp instruction offered |
| in_ready | output | 1 | Sequencer takes the offered warp at this edge |
| in_instr | input | 32 | Instruction word of the warp |
| in_mask | input | 32 | Per-thread active mask, bit t for thread t |
| in_pack | input | 1 | 1 selects packed lane mode for this warp |
| out_valid | output | 1 | A sub-group issues this cycle |
| out_instr | output | 32 | Instruction word of the issuing warp |
| out_sub | output | 1 | Index of the issuing sub-group |
| out_mask | output | 16 | Lane-active mask of the issue |
| out_lane_map | output | 80 | Original thread index per lane, 5 bits per lane |
| out_last | output | 1 | This issue is the last of its warp |

## Verification
The assertions assume that the warp fields stay stable and defined from the start of simulation, and that reset is held for at least one edge before the first warp is offered. The bench sets every input at its declaration, changes inputs only at falling edges, and keeps an offered warp's instruction, mask and mode unchanged until it has been accepted. Stimulus mixes full, single-half, all-zero, sparse and interleaved masks in both modes, and leaves random idle gaps between warps.

// File: rtl/subgroup_pkg.sv
package subgroup_pkg;
  localparam int WARP_THREADS = 32;
  localparam int SIMD_LANES   = 16;

  typedef enum logic {
    LANE_DIRECT = 1'b0,
    LANE_PACKED = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/sgi_pack.sv
module sgi_pack #(
  parameter int WARP_W = 32,
  parameter int SIMD_W = 16,
  parameter int NSUB   = WARP_W / SIMD_W,
  parameter int LIDX_W = $clog2(WARP_W)
) (
  input  logic [WARP_W-1:0]        thr_mask,
  input  logic                     packed_mode,
  output logic [WARP_W-1:0]        arr_mask,
  output logic [WARP_W*LIDX_W-1:0] arr_map,
  output logic [NSUB-1:0]          grp_nz
);
  localparam int MAP_W = WARP_W * LIDX_W;

  // Index of the n-th active thread placed in slot n; unused slots keep 0.
  function automatic logic [MAP_W-1:0] gather_map(input logic [WARP_W-1:0] m);
    int slot;
    slot = 0;
    gather_map = '0;
    for (int t = 0; t < WARP_W; t++) begin
      if (m[t]) begin
        gather_map[slot*LIDX_W +: LIDX_W] = LIDX_W'(t);
        slot++;
      end
    end
  endfunction

  // Thermometer mask: the lowest popcount(m) lanes set.
  function automatic logic [WARP_W-1:0] fill_low(input logic [WARP_W-1:0] m);
    int n;
    n = 0;
    for (int t = 0; t < WARP_W; t++) n += int'(m[t]);
    for (int t = 0; t < WARP_W; t++) fill_low[t] = (t < n);
  endfunction

  logic [MAP_W-1:0] ident_map;

  for (genvar t = 0; t < WARP_W; t++) begin : g_ident
    assign ident_map[t*LIDX_W +: LIDX_W] = LIDX_W'(t);
  end

  assign arr_mask = packed_mode ? fill_low(thr_mask)   : thr_mask;
  assign arr_map  = packed_mode ? gather_map(thr_mask) : ident_map;

  for (genvar g = 0; g < NSUB; g++) begin : g_nz
    assign grp_nz[g] = |arr_mask[g*SIMD_W +: SIMD_W];
  end

  always_comb begin
    AST_PACK_KEEPS_COUNT: assert ($countones(arr_mask) == $countones(thr_mask)); // R6
  end
endmodule

// File: rtl/sgi_select.sv
module sgi_select #(
  parameter int NSUB  = 2,
  parameter int SUB_W = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input  logic [NSUB-1:0]  pend,
  output logic [SUB_W-1:0] sel_idx,
  output logic [NSUB-1:0]  sel_onehot,
  output logic [NSUB-1:0]  rest
);
  logic found;

  always_comb begin
    sel_idx    = '0;
    sel_onehot = '0;
    found      = 1'b0;
    for (int g = 0; g < NSUB; g++) begin
      if (pend[g] && !found) begin
        sel_idx       = SUB_W'(g);
        sel_onehot[g] = 1'b1;
        found         = 1'b1;
      end
    end
    rest = pend & ~sel_onehot;
  end
endmodule

// File: rtl/subgroup_issue_seq.sv
module subgroup_issue_seq
  import subgroup_pkg::*;
#(
  parameter int WARP_W  = WARP_THREADS,
  parameter int SIMD_W  = SIMD_LANES,
  parameter int INSTR_W = 32,
  parameter int NSUB    = WARP_W / SIMD_W,
  parameter int SUB_W   = (NSUB > 1) ? $clog2(NSUB) : 1,
  parameter int LIDX_W  = $clog2(WARP_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [INSTR_W-1:0]       in_instr,
  input  logic [WARP_W-1:0]        in_mask,
  input  logic                     in_pack,
  output logic                     out_valid,
  output logic [INSTR_W-1:0]       out_instr,
  output logic [SUB_W-1:0]         out_sub,
  output logic [SIMD_W-1:0]        out_mask,
  output logic [SIMD_W*LIDX_W-1:0] out_lane_map,
  output logic                     out_last
);
  localparam int MAP_W  = WARP_W * LIDX_W;
  localparam int SMAP_W = SIMD_W * LIDX_W;

  logic [WARP_W-1:0]  new_mask;
  logic [MAP_W-1:0]   new_map;
  logic [NSUB-1:0]    new_nz;
  logic [NSUB-1:0]    pend_q;
  logic [WARP_W-1:0]  mask_q;
  logic [MAP_W-1:0]   map_q;
  logic [INSTR_W-1:0] instr_q;
  lane_mode_e         mode_q;
  logic [SUB_W-1:0]   sel_idx;
  logic [NSUB-1:0]    sel_onehot;
  logic [NSUB-1:0]    rest;
  logic               accept;

  sgi_pack #(.WARP_W(WARP_W), .SIMD_W(SIMD_W), .NSUB(NSUB), .LIDX_W(LIDX_W)) u_pack (
    .thr_mask    (in_mask),
    .packed_mode (in_pack),
    .arr_mask    (new_mask),
    .arr_map     (new_map),
    .grp_nz      (new_nz)
  );

  sgi_select #(.NSUB(NSUB), .SUB_W(SUB_W)) u_sel (
    .pend       (pend_q),
    .sel_idx    (sel_idx),
    .sel_onehot (sel_onehot),
    .rest       (rest)
  );

  assign in_ready = (rest == '0);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      map_q   <= '0;
      instr_q <= '0;
      mode_q  <= LANE_DIRECT;
    end else if (accept) begin
      pend_q  <= new_nz;
      mask_q  <= new_mask;
      map_q   <= new_map;
      instr_q <= in_instr;
      mode_q  <= lane_mode_e'(in_pack);
    end else begin
      pend_q  <= rest;
    end
  end

  assign out_valid    = |pend_q;
  assign out_sub      = sel_idx;
  assign out_mask     = mask_q[int'(sel_idx)*SIMD_W +: SIMD_W];
  assign out_lane_map = map_q[int'(sel_idx)*SMAP_W +: SMAP_W];
  assign out_instr    = instr_q;
  assign out_last     = out_valid && (rest == '0);

  AST_NO_EMPTY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0)); // R2
  AST_ASCENDING_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && (out_sub > $past(out_sub)))); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready); // R5
  AST_PACKED_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == LANE_PACKED) |-> ((out_mask & (out_mask + 1'b1)) == '0)); // R6
  AST_ZERO_WARP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_mask == '0) |=> !out_valid); // R7
  AST_INSTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> $stable(out_instr)); // R8
endmodule

// File: tb/subgroup_issue_seq_bench.sv
module subgroup_issue_seq_bench;
  localparam int WW = 32;
  localparam int SW = 16;
  localparam int IW = 32;
  localparam int LW = 5;

  typedef struct {
    int          sub;
    logic [15:0] mask;
    logic [79:0] map;
    logic [31:0] instr;
    bit          pk;
  } issue_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_mask = '0;
  logic        in_pack = 1'b0;
  logic        out_valid;
  logic [31:0] out_instr;
  logic [0:0]  out_sub;
  logic [15:0] out_mask;
  logic [79:0] out_lane_map;
  logic        out_last;

  int total = 0;
  int fails = 0;
  issue_t expq[$];

  always #4 clk = ~clk;

  subgroup_issue_seq u_subgroup_issue_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_mask(in_mask), .in_pack(in_pack),
    .out_valid(out_valid), .out_instr(out_instr), .out_sub(out_sub),
    .out_mask(out_mask), .out_lane_map(out_lane_map), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Reference: enumerate the issues a warp must produce.
  task automatic predict(input logic [31:0] m, input bit pk, input logic [31:0] ins);
    int act[$];
    issue_t it;
    if (!pk) begin
      for (int g = 0; g < WW / SW; g++) begin
        if (((m >> (g * SW)) & 32'hFFFF) != 0) begin
          it.sub = g; it.pk = 0; it.instr = ins;
          it.mask = 16'((m >> (g * SW)) & 32'hFFFF);
          it.map = '0;
          for (int l = 0; l < SW; l++) it.map[l*LW +: LW] = 5'(g * SW + l);
          expq.push_back(it);
        end
      end
    end else begin
      for (int t = 0; t < WW; t++) if (m[t]) act.push_back(t);
      for (int g = 0; g < WW / SW; g++) begin
        if (act.size() > g * SW) begin
          it.sub = g; it.pk = 1; it.instr = ins; it.mask = '0; it.map = '0;
          for (int l = 0; l < SW; l++) begin
            if (g * SW + l < act.size()) begin
              it.mask[l] = 1'b1;
              it.map[l*LW +: LW] = 5'(act[g * SW + l]);
            end
          end
          expq.push_back(it);
        end
      end
    end
  endtask

  function automatic logic [31:0] pick_mask(input int idx);
    case (idx)
      0: return 32'hFFFF_FFFF;
      1: return 32'h0000_FFFF;
      2: return 32'hFFFF_0000;
      3: return 32'h0000_0000;
      4: return 32'h5555_5555;
      5: return 32'h0001_0000;
      6: return 32'h8000_0001;
      7: return 32'h0001_FFFF;
      8: return 32'hF000_000F;
      default: begin
        case ($urandom % 6)
          0: return 32'h0;
          1: return 32'hFFFF_FFFF;
          2: return {16'h0, 16'($urandom)};
          3: return {16'($urandom), 16'h0};
          4: return $urandom & $urandom & $urandom;
          default: return $urandom;
        endcase
      end
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    total++;
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    issue_t e;
    bit hold;
    int nwarp;
    hold = 0;
    nwarp = 0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", 80'(out_valid), 80'(0));
      check(in_ready == 1'b1, "R1", "in_ready in reset", 80'(in_ready), 80'(1));
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 80'(out_valid), 80'(0));
    check(in_ready == 1'b1, "R1", "in_ready after reset", 80'(in_ready), 80'(1));
    for (int cyc = 0; cyc < 12000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      check(out_valid == (expq.size() > 0), "R3/R7", "out_valid",
            80'(out_valid), 80'(expq.size() > 0));
      check(in_ready == (expq.size() <= 1), "R5/R7", "in_ready",
            80'(in_ready), 80'(expq.size() <= 1));
      if (expq.size() > 0 && out_valid) begin
        e = expq[0];
        check(int'(out_sub) == e.sub, "R4", "out_sub", 80'(out_sub), 80'(e.sub));
        check(out_mask == e.mask, e.pk ? "R6" : "R2", "out_mask", 80'(out_mask), 80'(e.mask));
        check(out_lane_map == e.map, e.pk ? "R6" : "R9", "out_lane_map", out_lane_map, e.map);
        check(out_instr == e.instr, "R8", "out_instr", 80'(out_instr), 80'(e.instr));
        check(out_last == (expq.size() == 1), "R8", "out_last",
              80'(out_last), 80'(expq.size() == 1));
      end
      if (expq.size() > 0) void'(expq.pop_front());
      if (!hold) begin
        if (nwarp < 18 || ($urandom % 4) != 0) begin
          in_valid = 1'b1;
          in_mask  = pick_mask(nwarp < 18 ? nwarp % 9 : 99);
          in_pack  = (nwarp < 18) ? (nwarp >= 9) : 1'($urandom);
          in_instr = $urandom;
          nwarp++;
        end else begin
          in_valid = 1'b0;
        end
      end
      hold = in_valid && !in_ready;
      if (in_valid && in_ready) predict(in_mask, in_pack, in_instr);
    end
    summary();
    $finish;
  end
endmodule